// File: doc/BRIEF.md
# Lockable Instruction Cache Tag Controller

This block holds the tag and valid state of a set-associative, read-only instruction cache and decides what happens to each line fill. A fetch lookup is answered one cycle later with a hit or a miss and, on a hit, the matching way. A returning fill is either refreshed into the way that already holds its tag, placed into a way picked by an external replacement block, or dropped. The replacement block gets a same-cycle request carrying the set and the mask of ways it may choose from. It is notified of hits so it can age its state, and it receives a reset pulse whenever the cache is invalidated.

Three controls shape the fills. A global lock freezes the contents for misses issued while the lock is held, and fills of misses that were already in flight still land. A partial lock shrinks the replaceable region to the lower half or the lower quarter of the ways. Lines in the locked ways can still be refreshed on a tag match. A global invalidate clears every valid bit in one cycle, whatever the lock state. With the default parameters the cache has 8 ways and 64 sets, and each line holds 16 fetch units.

Top module: `ictag_ctrl`

## Requirements
- R1: Address fields are offset [3:0], set [9:4] and tag [19:10]. A lookup in cycle N reports in cycle N+1 either lk_hit_o with lk_way_o, or lk_miss_o with lk_way_o at 0. It is a hit only if the enable is high and a valid line of that set holds the same tag. With no lookup both flags are low, and after reset every output is 0.
- R2: While en_i is low, every lookup reports a miss and no fill is written.
- R3: inv_i clears every valid bit at the next edge, so later lookups miss until the lines are refilled. repl_reset_o is high in the cycle after inv_i.
- R4: A fill presented in the same cycle as inv_i is not written. The invalidate takes effect whether or not glock_i is high.
- R5: While glock_i is high, a hit is reported normally but raises no repl_touch_o. A fill whose miss was issued while glock_i was high is not written and raises no repl_req_o.
- R6: A fill whose miss was issued while glock_i was low is written normally, even if glock_i is high when the fill arrives.
- R7: repl_mask_o follows plock_i combinationally: 00 gives all ways (8'hFF), 01 gives ways 0 to 3 (8'h0F), and 10 or 11 gives ways 0 and 1 (8'h03).
- R8: A writable fill whose tag is in no valid way of its set raises repl_req_o in the same cycle, with repl_set_o set to the fill set. The next cycle shows fill_we_o with fill_way_o equal to repl_way_i and fill_set_o, provided repl_way_i is inside repl_mask_o. Otherwise the fill is dropped.
- R9: A writable fill whose tag matches a valid way is written back into that way, locked or not, and raises no repl_req_o.
- R10: A hit while glock_i is low raises repl_touch_o in the next cycle, carrying the set and the way.
- R11: A lookup sees the state from before the edge, so a lookup in the same cycle as the fill of its line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Cache enable |
| inv_i | input | 1 | Global invalidate command |
| glock_i | input | 1 | Global lock |
| plock_i | input | 2 | Partial lock selector |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 20 | Lookup fetch address |
| lk_id_i | input | 2 | Miss tag of the lookup |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss |
| lk_way_o | output | 3 | Hit way |
| fill_valid_i | input | 1 | Line fill arriving |
| fill_addr_i | input | 20 | Fill address |
| fill_id_i | input | 2 | Miss tag the fill answers |
| fill_we_o | output | 1 | Write the fill into the data array |
| fill_way_o | output | 3 | Way written |
| fill_set_o | output | 6 | Set written |
| repl_req_o | output | 1 | Victim request |
| repl_set_o | output | 6 | Set of the victim request |
| repl_mask_o | output | 8 | Ways the victim may come from |
| repl_way_i | input | 3 | Victim way answer |
| repl_touch_o | output | 1 | Hit notification for replacement state |
| repl_touch_set_o | output | 6 | Set of the hit |
| repl_touch_way_o | output | 3 | Way of the hit |
| repl_reset_o | output | 1 | Replacement state reset pulse |

## Verification
The key collisions are a fill meeting an invalidate, and a fill meeting a lookup to the same line. The first is provoked on purpose and again at random, and the judgement is that no write appears and that the line misses afterward. The second is provoked by presenting lookup and fill together, and the judgement is a miss followed by a hit one cycle later. A lock that changes between a miss and its fill is also driven on purpose, so the per-miss lock flag is checked against the lock level at issue time rather than at fill time.

// File: rtl/ictag_pkg.sv
package ictag_pkg;
    typedef enum logic [1:0] {
        PL_OPEN_ALL  = 2'b00,
        PL_OPEN_HALF = 2'b01,
        PL_OPEN_QTR  = 2'b10,
        PL_OPEN_QTR2 = 2'b11
    } plock_e;
endpackage

// File: rtl/ictag_openmask.sv
module ictag_openmask
    import ictag_pkg::*;
#(
    parameter int WAYS = 8
) (
    input  logic [1:0]      plock_i,
    output logic [WAYS-1:0] mask_o
);
    localparam int HALF = WAYS / 2;
    localparam int QTR  = WAYS / 4;

    plock_e sel;
    assign sel = plock_e'(plock_i);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb begin
            unique case (sel)
                PL_OPEN_ALL:  mask_o[w] = 1'b1;
                PL_OPEN_HALF: mask_o[w] = (w < HALF);
                default:      mask_o[w] = (w < QTR);
            endcase
        end
    end
endmodule

// File: rtl/ictag_match.sv
module ictag_match #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 10,
    parameter int WAY_W = 3
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            vld_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       any_o,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAYS-1:0] hv;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hv[w] = vld_i[w] && (tags_i[w] == tag_i);
    end

    assign any_o = |hv;

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hv[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ictag_ctrl.sv
module ictag_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int WAYS       = 8,
    parameter int SETS       = 64,
    parameter int LINE_UNITS = 16,
    parameter int IDS        = 4,
    localparam int OFF_W = $clog2(LINE_UNITS),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int ID_W  = $clog2(IDS),
    localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              inv_i,
    input  logic              glock_i,
    input  logic [1:0]        plock_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    input  logic [ID_W-1:0]   lk_id_i,
    output logic              lk_hit_o,
    output logic              lk_miss_o,
    output logic [WAY_W-1:0]  lk_way_o,
    input  logic              fill_valid_i,
    input  logic [ADDR_W-1:0] fill_addr_i,
    input  logic [ID_W-1:0]   fill_id_i,
    output logic              fill_we_o,
    output logic [WAY_W-1:0]  fill_way_o,
    output logic [SET_W-1:0]  fill_set_o,
    output logic              repl_req_o,
    output logic [SET_W-1:0]  repl_set_o,
    output logic [WAYS-1:0]   repl_mask_o,
    input  logic [WAY_W-1:0]  repl_way_i,
    output logic              repl_touch_o,
    output logic [SET_W-1:0]  repl_touch_set_o,
    output logic [WAY_W-1:0]  repl_touch_way_o,
    output logic              repl_reset_o
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [IDS-1:0]                        noalloc;
        logic                                  hit;
        logic                                  miss;
        logic [WAY_W-1:0]                      way;
        logic                                  touch;
        logic [SET_W-1:0]                      tset;
        logic [WAY_W-1:0]                      tway;
        logic                                  fwe;
        logic [WAY_W-1:0]                      fway;
        logic [SET_W-1:0]                      fset;
        logic                                  rrst;
    } state_t;

    state_t st_d, st_q;

    logic [SET_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic             lk_any, fl_any;
    logic [WAY_W-1:0] lk_mway, fl_mway;
    logic [WAYS-1:0]  open_mask;
    logic             fl_ok;

    assign lk_set = lk_addr_i[OFF_W +: SET_W];
    assign lk_tag = lk_addr_i[ADDR_W-1 -: TAG_W];
    assign fl_set = fill_addr_i[OFF_W +: SET_W];
    assign fl_tag = fill_addr_i[ADDR_W-1 -: TAG_W];

    ictag_openmask #(.WAYS(WAYS)) u_mask (
        .plock_i (plock_i),
        .mask_o  (open_mask)
    );

    ictag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
        .tags_i (st_q.tag[lk_set]),
        .vld_i  (st_q.vld[lk_set]),
        .tag_i  (lk_tag),
        .any_o  (lk_any),
        .way_o  (lk_mway)
    );

    ictag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
        .tags_i (st_q.tag[fl_set]),
        .vld_i  (st_q.vld[fl_set]),
        .tag_i  (fl_tag),
        .any_o  (fl_any),
        .way_o  (fl_mway)
    );

    // A fill may write only when enabled, not pre-empted by an invalidate,
    // and its miss was issued outside global lock.
    assign fl_ok = fill_valid_i && en_i && !inv_i && !st_q.noalloc[fill_id_i];

    always_comb begin
        st_d       = st_q;
        st_d.hit   = 1'b0;
        st_d.miss  = 1'b0;
        st_d.way   = '0;
        st_d.touch = 1'b0;
        st_d.tset  = '0;
        st_d.tway  = '0;
        st_d.fwe   = 1'b0;
        st_d.fway  = '0;
        st_d.fset  = '0;
        st_d.rrst  = 1'b0;

        if (lk_valid_i) begin
            if (en_i && lk_any) begin
                st_d.hit = 1'b1;
                st_d.way = lk_mway;
                if (!glock_i) begin
                    st_d.touch = 1'b1;
                    st_d.tset  = lk_set;
                    st_d.tway  = lk_mway;
                end
            end else begin
                st_d.miss                = 1'b1;
                st_d.noalloc[lk_id_i]    = glock_i;
            end
        end

        if (fl_ok) begin
            if (fl_any) begin
                st_d.fwe  = 1'b1;
                st_d.fway = fl_mway;
            end else if (open_mask[repl_way_i]) begin
                st_d.fwe  = 1'b1;
                st_d.fway = repl_way_i;
            end
            if (st_d.fwe) begin
                st_d.fset                       = fl_set;
                st_d.vld[fl_set][st_d.fway]     = 1'b1;
                st_d.tag[fl_set][st_d.fway]     = fl_tag;
            end
        end

        if (inv_i) begin
            st_d.vld  = '0;
            st_d.rrst = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lk_hit_o         = st_q.hit;
    assign lk_miss_o        = st_q.miss;
    assign lk_way_o         = st_q.way;
    assign fill_we_o        = st_q.fwe;
    assign fill_way_o       = st_q.fway;
    assign fill_set_o       = st_q.fset;
    assign repl_req_o       = fl_ok && !fl_any;
    assign repl_set_o       = fl_set;
    assign repl_mask_o      = open_mask;
    assign repl_touch_o     = st_q.touch;
    assign repl_touch_set_o = st_q.tset;
    assign repl_touch_way_o = st_q.tway;
    assign repl_reset_o     = st_q.rrst;
endmodule

// File: rtl/ictag_ctrl_chk.sv
module ictag_ctrl_chk #(
    parameter int WAYS  = 8,
    parameter int WAY_W = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic             inv_i,
    input logic             glock_i,
    input logic             lk_valid_i,
    input logic             lk_hit_o,
    input logic             lk_miss_o,
    input logic             fill_we_o,
    input logic             repl_req_o,
    input logic [WAYS-1:0]  repl_mask_o,
    input logic [WAY_W-1:0] repl_way_i,
    input logic             repl_reset_o,
    input logic             repl_touch_o
);
    AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lk_hit_o && lk_miss_o)); // R1
    AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_valid_i |=> !lk_hit_o && !lk_miss_o); // R1
    AST_OFF_MISSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_valid_i && !en_i |=> lk_miss_o); // R2
    AST_OFF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !fill_we_o); // R2
    AST_INV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_i |=> repl_reset_o); // R3
    AST_INV_BLOCKS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_i |=> !fill_we_o); // R4
    AST_LOCK_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        glock_i |=> !repl_touch_o); // R5
    AST_VICTIM_IN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        repl_req_o && !repl_mask_o[repl_way_i] |=> !fill_we_o); // R8
    AST_TOUCH_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        repl_touch_o |-> lk_hit_o); // R10
endmodule

bind ictag_ctrl ictag_ctrl_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) chk_i (.*);

// File: tb/ictag_ctrl_tb.sv
`timescale 1ns/1ps
module ictag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, inv = 1'b0, glock = 1'b0;
    logic [1:0] plock = 2'b00;
    logic       lkv = 1'b0, fv = 1'b0;
    logic [19:0] lka = '0, fa = '0;
    logic [1:0] lkid = '0, fid = '0;
    logic [2:0] rway = '0;

    logic       hit, miss, fwe, rreq, touch, rrst;
    logic [2:0] way, fway, tway;
    logic [5:0] fset, rset, tset;
    logic [7:0] rmask;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    ictag_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .inv_i(inv), .glock_i(glock),
        .plock_i(plock), .lk_valid_i(lkv), .lk_addr_i(lka), .lk_id_i(lkid),
        .lk_hit_o(hit), .lk_miss_o(miss), .lk_way_o(way),
        .fill_valid_i(fv), .fill_addr_i(fa), .fill_id_i(fid),
        .fill_we_o(fwe), .fill_way_o(fway), .fill_set_o(fset),
        .repl_req_o(rreq), .repl_set_o(rset), .repl_mask_o(rmask), .repl_way_i(rway),
        .repl_touch_o(touch), .repl_touch_set_o(tset), .repl_touch_way_o(tway),
        .repl_reset_o(rrst)
    );

    // reference model state
    bit rv [64][8];
    int rt [64][8];
    bit rna [4];

    task automatic chk(input int act, input int exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int find(input int s, input int t);
        for (int w = 0; w < 8; w++) if (rv[s][w] && rt[s][w] == t) return w;
        return -1;
    endfunction

    // one clock: combinational checks, model advance, registered checks
    task automatic step();
        int ls, lt, fs, ft, lw, fw, m;
        int e_hit, e_miss, e_way, e_touch, e_tset, e_tway, e_fwe, e_fway, e_fset, e_req;
        #1;
        ls = int'(lka[9:4]); lt = int'(lka[19:10]);
        fs = int'(fa[9:4]);  ft = int'(fa[19:10]);
        m  = (plock == 2'b00) ? 8'hFF : (plock == 2'b01) ? 8'h0F : 8'h03;
        lw = find(ls, lt);
        fw = find(fs, ft);
        e_req = (fv && en && !inv && !rna[fid] && fw < 0) ? 1 : 0;
        chk(int'(rmask), m, "R7 repl_mask");
        chk(int'(rreq), e_req, "R8 repl_req");
        chk(int'(rset), fs, "R8 repl_set");

        e_hit = 0; e_miss = 0; e_way = 0; e_touch = 0; e_tset = 0; e_tway = 0;
        e_fwe = 0; e_fway = 0; e_fset = 0;
        if (lkv) begin
            if (en && lw >= 0) begin
                e_hit = 1; e_way = lw;
                if (!glock) begin e_touch = 1; e_tset = ls; e_tway = lw; end
            end else e_miss = 1;
        end
        if (fv && en && !inv && !rna[fid]) begin
            if (fw >= 0) begin e_fwe = 1; e_fway = fw; end
            else if (m[rway]) begin e_fwe = 1; e_fway = int'(rway); end
            if (e_fwe == 1) begin
                e_fset = fs;
                rv[fs][e_fway] = 1'b1;
                rt[fs][e_fway] = ft;
            end
        end
        if (lkv && e_miss == 1) rna[lkid] = glock;
        if (inv) foreach (rv[s, w]) rv[s][w] = 1'b0;

        @(posedge clk);
        #1;
        chk(int'(hit), e_hit, "R1 hit");
        chk(int'(miss), e_miss, "R1 miss");
        chk(int'(way), e_way, "R1 way");
        chk(int'(touch), e_touch, "R10 touch");
        chk(int'(tset), e_tset, "R10 touch set");
        chk(int'(tway), e_tway, "R10 touch way");
        chk(int'(fwe), e_fwe, "R8 fill_we");
        chk(int'(fway), e_fway, "R8 fill_way");
        chk(int'(fset), e_fset, "R8 fill_set");
        chk(int'(rrst), inv ? 1 : 0, "R3 repl_reset");
    endtask

    task automatic idle();
        lkv = 0; fv = 0; inv = 0;
    endtask

    function automatic logic [19:0] mk(input int t, input int s);
        return {t[9:0], s[5:0], 4'h3};
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // reset state (R1)
        chk(int'(hit | miss | fwe | touch | rrst), 0, "R1 reset outputs");
        en = 1;
        // miss then fill with open victim, then hit (R1, R8, R10)
        lkv = 1; lka = mk(1, 5); lkid = 0; step(); idle();
        chk(int'(miss), 1, "R1 first lookup misses");
        fv = 1; fa = mk(1, 5); fid = 0; rway = 5; step(); idle();
        chk(int'(fwe), 1, "R8 fill written");
        lkv = 1; lka = mk(1, 5); step(); idle();
        chk(int'(hit), 1, "R1 hit after fill");
        chk(int'(touch), 1, "R10 touch on hit");
        // lookup and fill of the same line together (R11)
        lkv = 1; lka = mk(2, 7); lkid = 1; step(); idle();
        lkv = 1; lka = mk(2, 7); fv = 1; fa = mk(2, 7); fid = 1; rway = 0; step(); idle();
        chk(int'(miss), 1, "R11 same-cycle lookup misses");
        lkv = 1; lka = mk(2, 7); step(); idle();
        chk(int'(hit), 1, "R11 hit one cycle later");
        // partial lock: victim in a locked way dropped, refresh allowed (R7, R9)
        plock = 2'b10;
        lkv = 1; lka = mk(3, 5); lkid = 2; step(); idle();
        fv = 1; fa = mk(3, 5); fid = 2; rway = 5; step(); idle();
        chk(int'(fwe), 0, "R7 locked victim dropped");
        fv = 1; fa = mk(1, 5); fid = 0; rway = 0; step(); idle();
        chk(int'(fwe), 1, "R9 refresh of locked way");
        chk(int'(fway), 5, "R9 refresh way");
        plock = 2'b00;
        // global lock: old miss completes, new miss does not (R5, R6)
        lkv = 1; lka = mk(4, 9); lkid = 1; step(); idle();
        glock = 1;
        lkv = 1; lka = mk(5, 9); lkid = 2; step(); idle();
        fv = 1; fa = mk(5, 9); fid = 2; rway = 3; step(); idle();
        chk(int'(fwe), 0, "R5 locked miss not filled");
        fv = 1; fa = mk(4, 9); fid = 1; rway = 3; step(); idle();
        chk(int'(fwe), 1, "R6 earlier miss filled under lock");
        lkv = 1; lka = mk(1, 5); step(); idle();
        chk(int'(hit), 1, "R5 hit under lock");
        chk(int'(touch), 0, "R5 no touch under lock");
        // invalidate under lock, together with a fill (R3, R4)
        inv = 1; fv = 1; fa = mk(6, 2); fid = 0; rway = 1; step(); idle();
        chk(int'(fwe), 0, "R4 fill beaten by invalidate");
        glock = 0;
        lkv = 1; lka = mk(1, 5); step(); idle();
        chk(int'(miss), 1, "R3 line gone after invalidate");
        // disabled cache (R2)
        fv = 1; fa = mk(1, 5); fid = 0; rway = 2; step(); idle();
        en = 0;
        lkv = 1; lka = mk(1, 5); lkid = 3; step(); idle();
        chk(int'(miss), 1, "R2 disabled lookup misses");
        fv = 1; fa = mk(7, 5); fid = 3; rway = 4; step(); idle();
        chk(int'(fwe), 0, "R2 disabled fill dropped");
        en = 1;
        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            lkv   = ($urandom % 3) != 0;
            lka   = mk($urandom % 4, $urandom % 3);
            lkid  = 2'($urandom);
            fv    = ($urandom % 3) == 0;
            fa    = mk($urandom % 4, $urandom % 3);
            fid   = 2'($urandom);
            rway  = 3'($urandom);
            inv   = ($urandom % 97) == 0;
            if (($urandom % 50) == 0) glock = ~glock;
            if (($urandom % 60) == 0) plock = 2'($urandom);
            en    = ($urandom % 40) != 0;
            step();
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule